// File: doc/BRIEF.md
# Serial Clock Divisor Search Engine

This block picks a two-level divider setting for a serial port. The two inputs are a reference clock frequency and a wanted bit rate, both in hertz. The setting is a prescale factor and a rate divider. The divided rate is the reference divided by `prescale * (rate_div + 1)`, with the fraction dropped. The block searches a bounded grid of settings, one candidate per clock, in two passes that walk the grid in opposite orders. Each pass stops at its own rule. A small iterative divider then works out the rate that each pass's setting gives, and the block returns the faster of the two.

A request is launched with a one-cycle `start_i`, and the inputs are captured at that moment. The block reports back with a one-cycle `done_o`. Its result registers keep their values until the next successful search. If the request cannot be met, the block raises `err_o` alongside `done_o` and leaves the result untouched. The grid bounds, the data widths and the number of quotient bits the divider resolves per cycle are all parameters.

Top module: `clkdiv_search`

## Requirements
- R1: A wanted rate of zero, or one for which twice the wanted rate exceeds the reference, is rejected: `done_o` and `err_o` are both high two cycles after `start_i`, and `pre_o`, `rdiv_o` and `freq_o` keep their previous values.
- R2: On a successful search, `freq_o` equals floor(reference / (`pre_o` * (`rdiv_o` + 1))).
- R3: Pass one walks `rdiv` from 0 to RD_END-1 as the outer loop and `pre` from PRE_MIN to PRE_END-1 as the inner loop. The first candidate whose rate equals the wanted rate ends the search with that setting, and pass two is skipped (its rate counts as zero).
- R4: Pass one also stops at the first candidate whose rate is below the wanted rate. That setting becomes the pass-one result, and pass two then starts.
- R5: Pass two walks `pre` as the outer loop and `rdiv` as the inner loop, over the same ranges. It stops at the first candidate whose rate is at or below the wanted rate.
- R6: The reported setting is the pass-one setting when its rate is greater than or equal to the pass-two rate. Otherwise it is the pass-two setting.
- R7: A pass that runs through its whole grid without stopping keeps the last setting it tried. When no candidate reaches the wanted rate, the result is therefore `pre` = PRE_END-1 and `rdiv` = RD_END-1.
- R8: `done_o` is high for exactly one cycle per accepted request, and `err_o` is low on every successful search. A `start_i` seen while a search is running is ignored and does not change that search's result.
- R9: After reset, `done_o`, `err_o`, `pre_o`, `rdiv_o` and `freq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse; inputs captured when idle |
| ref_hz_i | input | FW | Reference clock frequency in Hz |
| want_hz_i | input | FW | Wanted serial bit rate in Hz |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected, valid with done_o |
| pre_o | output | DIV_W | Chosen prescale factor |
| rdiv_o | output | DIV_W | Chosen rate divider (divides by rdiv_o+1) |
| freq_o | output | FW | Rate achieved by the chosen setting |

## Verification
The bench runs a reduced grid. For one small reference it tries every wanted rate from zero to just past the legal limit. For two larger references it strides through the wanted rates. These sweeps separate exact hits in pass one from early stops below the target, and both of those from outcomes where the pass-two setting wins. A wanted rate far below anything the grid can reach separates the exhaustion fallback from a normal stop. The largest reference, paired with half its value and with half plus one, checks the legality limit right at its edge. A second start pulse sent during a running search shows whether the running search keeps its captured inputs.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SWEEP1,
      ST_SWEEP2,
      ST_LOAD1,
      ST_WAIT1,
      ST_LOAD2,
      ST_WAIT2,
      ST_PICK,
      ST_REJ
   } srch_st_e;

endpackage

// File: rtl/clkdiv_cand_cmp.sv
// Compares one candidate setting against the wanted rate without dividing:
// floor(ref/d) <  want  <=>  ref <  want*d
// floor(ref/d) <= want  <=>  ref < (want+1)*d
module clkdiv_cand_cmp #(
   parameter int FW    = 32,
   parameter int DIV_W = 8,
   parameter int DW    = 16
) (
   input  logic [FW-1:0]    ref_i,
   input  logic [FW-1:0]    want_i,
   input  logic [DIV_W-1:0] pre_i,
   input  logic [DIV_W-1:0] rd_i,
   output logic             eq_o,
   output logic             below_o,
   output logic             le_o
);
   localparam int PW2 = 2*DIV_W + 1;
   localparam int PW  = FW + 1 + DW;

   logic [PW2-1:0] d_full;
   logic [DW-1:0]  d;
   logic [PW-1:0]  lo_p, hi_p, rf_p;

   assign d_full  = PW2'(pre_i) * (PW2'(rd_i) + PW2'(1));
   assign d       = d_full[DW-1:0];
   assign lo_p    = PW'(want_i) * PW'(d);
   assign hi_p    = lo_p + PW'(d);
   assign rf_p    = PW'(ref_i);
   assign below_o = rf_p < lo_p;
   assign le_o    = rf_p < hi_p;
   assign eq_o    = le_o && !below_o;
endmodule

// File: rtl/clkdiv_iter_div.sv
// Restoring divider, BPC quotient bits resolved per cycle.
module clkdiv_iter_div #(
   parameter int NW  = 32,
   parameter int DW  = 16,
   parameter int BPC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [NW-1:0] num_i,
   input  logic [DW-1:0] den_i,
   output logic [NW-1:0] quot_o,
   output logic          valid_o
);
   localparam int STEPS = NW / BPC;
   localparam int CW    = $clog2(STEPS + 1);

   if (BPC < 1 || (NW % BPC) != 0) begin : g_bad_bpc
      $error("clkdiv_iter_div: BPC must divide NW");
   end

   logic [DW-1:0] rem_q, den_q, rem_n;
   logic [NW-1:0] quo_q, quo_n;
   logic [CW-1:0] cnt_q;
   logic          run_q, valid_q;

   if (BPC == 1) begin : g_single
      logic [DW:0] sh;
      logic        ge;
      always_comb begin
         sh    = {rem_q, quo_q[NW-1]};
         ge    = sh >= {1'b0, den_q};
         rem_n = ge ? DW'(sh - {1'b0, den_q}) : sh[DW-1:0];
         quo_n = {quo_q[NW-2:0], ge};
      end
   end else begin : g_multi
      always_comb begin
         logic [DW-1:0] r;
         logic [NW-1:0] q;
         logic [DW:0]   sh;
         r = rem_q;
         q = quo_q;
         for (int k = 0; k < BPC; k++) begin
            sh = {r, q[NW-1]};
            q  = {q[NW-2:0], 1'b0};
            if (sh >= {1'b0, den_q}) begin
               sh   = sh - {1'b0, den_q};
               q[0] = 1'b1;
            end
            r = sh[DW-1:0];
         end
         rem_n = r;
         quo_n = q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= '0;
         den_q   <= '0;
         quo_q   <= '0;
         cnt_q   <= '0;
         run_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (go_i) begin
            rem_q <= '0;
            den_q <= den_i;
            quo_q <= num_i;
            cnt_q <= CW'(STEPS);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               run_q   <= 1'b0;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign quot_o  = quo_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search #(
   parameter int FW      = 32,
   parameter int DIV_W   = 8,
   parameter int PRE_MIN = 2,
   parameter int PRE_END = 254,
   parameter int RD_END  = 255,
   parameter int BPC     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [FW-1:0]    ref_hz_i,
   input  logic [FW-1:0]    want_hz_i,
   output logic             done_o,
   output logic             err_o,
   output logic [DIV_W-1:0] pre_o,
   output logic [DIV_W-1:0] rdiv_o,
   output logic [FW-1:0]    freq_o
);
   import clkdiv_pkg::*;

   localparam int DMAX = (PRE_END - 1) * RD_END;
   localparam int DW   = $clog2(DMAX + 1);
   localparam int PW2  = 2*DIV_W + 1;
   localparam logic [DIV_W-1:0] PRE_LO   = DIV_W'(PRE_MIN);
   localparam logic [DIV_W-1:0] PRE_LAST = DIV_W'(PRE_END - 1);
   localparam logic [DIV_W-1:0] RD_LAST  = DIV_W'(RD_END - 1);

   if (PRE_MIN < 1 || PRE_END <= PRE_MIN || PRE_END > (1 << DIV_W)) begin : g_bad_pre
      $error("clkdiv_search: prescale range does not fit");
   end
   if (RD_END < 1 || RD_END > (1 << DIV_W)) begin : g_bad_rd
      $error("clkdiv_search: rate divider range does not fit");
   end

   srch_st_e         st_q;
   logic [FW-1:0]    ref_q, want_q, f1_q, f2_q, div_q;
   logic [DIV_W-1:0] pre_c, rd_c, pre1_q, rd1_q, pre2_q, rd2_q;
   logic             exact_q;
   logic             eq_c, below_c, le_c;
   logic             div_go, div_valid;
   logic [PW2-1:0]   d1_full, d2_full;
   logic [DW-1:0]    den;
   logic             bad_req;
   logic             row_end, grid_end;

   clkdiv_cand_cmp #(.FW(FW), .DIV_W(DIV_W), .DW(DW)) u_cmp (
      .ref_i  (ref_q),
      .want_i (want_q),
      .pre_i  (pre_c),
      .rd_i   (rd_c),
      .eq_o   (eq_c),
      .below_o(below_c),
      .le_o   (le_c)
   );

   assign d1_full = PW2'(pre1_q) * (PW2'(rd1_q) + PW2'(1));
   assign d2_full = PW2'(pre2_q) * (PW2'(rd2_q) + PW2'(1));
   assign den     = (st_q == ST_LOAD2) ? d2_full[DW-1:0] : d1_full[DW-1:0];
   assign div_go  = (st_q == ST_LOAD1) || (st_q == ST_LOAD2);

   clkdiv_iter_div #(.NW(FW), .DW(DW), .BPC(BPC)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_go),
      .num_i  (ref_q),
      .den_i  (den),
      .quot_o (div_q),
      .valid_o(div_valid)
   );

   assign bad_req  = (want_hz_i == '0) || ({want_hz_i, 1'b0} > {1'b0, ref_hz_i});
   assign grid_end = (pre_c == PRE_LAST) && (rd_c == RD_LAST);
   assign row_end  = (st_q == ST_SWEEP1) ? (pre_c == PRE_LAST) : (rd_c == RD_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         ref_q   <= '0;
         want_q  <= '0;
         pre_c   <= '0;
         rd_c    <= '0;
         pre1_q  <= '0;
         rd1_q   <= '0;
         pre2_q  <= '0;
         rd2_q   <= '0;
         exact_q <= 1'b0;
         f1_q    <= '0;
         f2_q    <= '0;
         pre_o   <= '0;
         rdiv_o  <= '0;
         freq_o  <= '0;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               if (bad_req) begin
                  st_q <= ST_REJ;
               end else begin
                  ref_q  <= ref_hz_i;
                  want_q <= want_hz_i;
                  pre_c  <= PRE_LO;
                  rd_c   <= '0;
                  st_q   <= ST_SWEEP1;
               end
            end
            ST_SWEEP1: begin
               if (eq_c || below_c || grid_end) begin
                  pre1_q  <= pre_c;
                  rd1_q   <= rd_c;
                  exact_q <= eq_c;
                  pre_c   <= PRE_LO;
                  rd_c    <= '0;
                  st_q    <= eq_c ? ST_LOAD1 : ST_SWEEP2;
               end else if (row_end) begin
                  pre_c <= PRE_LO;
                  rd_c  <= rd_c + DIV_W'(1);
               end else begin
                  pre_c <= pre_c + DIV_W'(1);
               end
            end
            ST_SWEEP2: begin
               if (le_c || grid_end) begin
                  pre2_q <= pre_c;
                  rd2_q  <= rd_c;
                  st_q   <= ST_LOAD1;
               end else if (row_end) begin
                  rd_c  <= '0;
                  pre_c <= pre_c + DIV_W'(1);
               end else begin
                  rd_c <= rd_c + DIV_W'(1);
               end
            end
            ST_LOAD1: st_q <= ST_WAIT1;
            ST_WAIT1: if (div_valid) begin
               f1_q <= div_q;
               if (exact_q) begin
                  f2_q <= '0;
                  st_q <= ST_PICK;
               end else begin
                  st_q <= ST_LOAD2;
               end
            end
            ST_LOAD2: st_q <= ST_WAIT2;
            ST_WAIT2: if (div_valid) begin
               f2_q <= div_q;
               st_q <= ST_PICK;
            end
            ST_PICK: begin
               if (f1_q >= f2_q) begin
                  pre_o  <= pre1_q;
                  rdiv_o <= rd1_q;
                  freq_o <= f1_q;
               end else begin
                  pre_o  <= pre2_q;
                  rdiv_o <= rd2_q;
                  freq_o <= f2_q;
               end
               done_o <= 1'b1;
               st_q   <= ST_IDLE;
            end
            ST_REJ: begin
               done_o <= 1'b1;
               err_o  <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/clkdiv_search_chk.sv
module clkdiv_search_chk #(
   parameter int FW      = 32,
   parameter int DIV_W   = 8,
   parameter int PRE_MIN = 2,
   parameter int PRE_END = 254,
   parameter int RD_END  = 255
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [FW-1:0]    ref_hz_i,
   input logic [FW-1:0]    want_hz_i,
   input logic             done_o,
   input logic             err_o,
   input logic [DIV_W-1:0] pre_o,
   input logic [DIV_W-1:0] rdiv_o,
   input logic [FW-1:0]    freq_o
);
   localparam int PW2 = 2*DIV_W + 1;

   logic          pend_q;
   logic          acc;
   logic [FW-1:0] ref_k, want_k;
   logic [PW2-1:0] dd;
   logic [FW:0]    want2;
   logic [FW-1:0]  f_exp;

   assign acc   = start_i && (!pend_q || done_o);
   assign dd    = PW2'(pre_o) * (PW2'(rdiv_o) + PW2'(1));
   assign f_exp = (dd == '0) ? '0 : FW'(ref_k / FW'(dd));
   assign want2 = {want_k, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         ref_k  <= '0;
         want_k <= '0;
      end else begin
         pend_q <= done_o ? start_i : (pend_q | start_i);
         if (acc) begin
            ref_k  <= ref_hz_i;
            want_k <= want_hz_i;
         end
      end
   end

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> pend_q);

   a_r1_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);

   a_r1_err_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> ($stable(pre_o) && $stable(rdiv_o) && $stable(freq_o)));

   a_r1_legal_on_success: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (want_k != '0 && want2 <= {1'b0, ref_k}));

   a_r7_pair_in_grid: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (int'(pre_o) >= PRE_MIN && int'(pre_o) < PRE_END
                              && int'(rdiv_o) < RD_END));

   a_r2_freq_of_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (freq_o == f_exp));
endmodule

bind clkdiv_search clkdiv_search_chk #(
   .FW(FW), .DIV_W(DIV_W), .PRE_MIN(PRE_MIN), .PRE_END(PRE_END), .RD_END(RD_END)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .ref_hz_i (ref_hz_i),
   .want_hz_i(want_hz_i),
   .done_o   (done_o),
   .err_o    (err_o),
   .pre_o    (pre_o),
   .rdiv_o   (rdiv_o),
   .freq_o   (freq_o)
);

// File: tb/clkdiv_search_tb.sv
`timescale 1ns/1ps
module clkdiv_search_tb_top;
   localparam int FW      = 32;
   localparam int DIV_W   = 8;
   localparam int PRE_MIN = 2;
   localparam int PRE_END = 34;
   localparam int RD_END  = 31;
   localparam int BPC     = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [FW-1:0]    ref_hz_i = '0;
   logic [FW-1:0]    want_hz_i = '0;
   logic             done_o, err_o;
   logic [DIV_W-1:0] pre_o, rdiv_o;
   logic [FW-1:0]    freq_o;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   clkdiv_search #(
      .FW(FW), .DIV_W(DIV_W), .PRE_MIN(PRE_MIN), .PRE_END(PRE_END),
      .RD_END(RD_END), .BPC(BPC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_hz_i(ref_hz_i),
      .want_hz_i(want_hz_i), .done_o(done_o), .err_o(err_o), .pre_o(pre_o),
      .rdiv_o(rdiv_o), .freq_o(freq_o)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Arithmetic model of the two-pass search; kind: 0 exact, 1 exhausted,
   // 2 pass one chosen, 3 pass two chosen.
   function automatic void model(input longint rf, input longint wt,
                                 output int p_o, output int s_o,
                                 output longint f_o, output int kind);
      int p1 = PRE_END - 1, s1 = RD_END - 1, p2 = PRE_END - 1, s2 = RD_END - 1;
      bit ex = 0, hit1 = 0, hit2 = 0;
      longint q, f1, f2;
      for (int s = 0; s < RD_END && !hit1; s++)
         for (int p = PRE_MIN; p < PRE_END && !hit1; p++) begin
            q = rf / (p * (s + 1));
            if (q == wt) begin ex = 1; hit1 = 1; p1 = p; s1 = s; end
            else if (q < wt) begin hit1 = 1; p1 = p; s1 = s; end
         end
      f1 = rf / (p1 * (s1 + 1));
      if (ex) f2 = 0;
      else begin
         for (int p = PRE_MIN; p < PRE_END && !hit2; p++)
            for (int s = 0; s < RD_END && !hit2; s++) begin
               q = rf / (p * (s + 1));
               if (q <= wt) begin hit2 = 1; p2 = p; s2 = s; end
            end
         f2 = rf / (p2 * (s2 + 1));
      end
      if (f1 >= f2) begin p_o = p1; s_o = s1; f_o = f1; end
      else begin p_o = p2; s_o = s2; f_o = f2; end
      kind = ex ? 0 : (!hit1 ? 1 : (f1 >= f2 ? 2 : 3));
   endfunction

   task automatic wait_done(output bit seen);
      int cyc = 0;
      while (!done_o && cyc < 6000) begin
         @(negedge clk);
         cyc++;
      end
      seen = done_o;
   endtask

   task automatic check_result(input longint rf, input longint wt,
                               input int prev_p, input int prev_s, input longint prev_f);
      bit legal;
      int ep, es, kind;
      longint ef;
      string tag;
      legal = (wt != 0) && (2 * wt <= rf);
      if (!legal) begin
         chk(err_o == 1'b1, "R1 err flag", err_o, 1);
         chk(pre_o == prev_p && rdiv_o == prev_s && freq_o == prev_f,
             "R1 result unchanged", pre_o, prev_p);
      end else begin
         model(rf, wt, ep, es, ef, kind);
         case (kind)
            0: tag = "R3 exact";
            1: tag = "R7 exhausted";
            2: tag = "R6 pick, R4 pass one";
            default: tag = "R6 pick, R5 pass two";
         endcase
         chk(err_o == 1'b0, "R8 err low", err_o, 0);
         chk(pre_o == ep, {tag, " prescale"}, pre_o, ep);
         chk(rdiv_o == es, {tag, " rate divider"}, rdiv_o, es);
         chk(freq_o == ef, "R2 freq", freq_o, ef);
      end
   endtask

   task automatic run_case(input longint rf, input longint wt);
      int pp, ps;
      longint pf;
      bit seen;
      pp = pre_o; ps = rdiv_o; pf = freq_o;
      @(negedge clk);
      ref_hz_i = rf[FW-1:0];
      want_hz_i = wt[FW-1:0];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done(seen);
      chk(seen, "R8 done seen", seen, 1);
      if (seen) begin
         check_result(rf, wt, pp, ps, pf);
         @(negedge clk);
         chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
      end
   endtask

   initial begin
      #(190000 * 8);
      if (!finished) begin
         n_fail++;
         n_run++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset values
      chk(done_o == 0 && err_o == 0, "R9 flags after reset", {done_o, err_o}, 0);
      chk(pre_o == 0 && rdiv_o == 0 && freq_o == 0, "R9 result after reset", pre_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Full sweep of wanted rate for a small reference (covers R1 edge at 50/51)
      for (int w = 0; w <= 52; w++) run_case(100, w);
      // Strided sweeps over larger references
      for (int w = 0; w <= 501; w += 3) run_case(1000, w);
      for (int w = 1; w <= 2501; w += 97) run_case(5000, w);
      // R7: nothing in the grid reaches the wanted rate
      run_case(4000, 1);
      // R1 boundary at the full input width
      run_case(64'hFFFF_FFFF, 64'h7FFF_FFFF);
      run_case(64'hFFFF_FFFF, 64'h8000_0000);
      run_case(64'hFFFF_FFFF, 0);

      // R8: a second start during a running search is ignored
      begin
         int pp, ps;
         longint pf;
         bit seen;
         pp = pre_o; ps = rdiv_o; pf = freq_o;
         @(negedge clk);
         ref_hz_i = 1000; want_hz_i = 7; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         @(negedge clk);
         ref_hz_i = 100; want_hz_i = 50; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         wait_done(seen);
         chk(seen, "R8 done after busy start", seen, 1);
         if (seen) check_result(1000, 7, pp, ps, pf);
         @(negedge clk);
         chk(done_o == 1'b0, "R8 no second done", done_o, 0);
         repeat (40) @(negedge clk);
         chk(done_o == 1'b0, "R8 ignored start gives no done", done_o, 0);
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule